// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block chooses the two ALU operands of the instruction sitting in the execute stage of a five-stage in-order pipeline. It compares the two source register indices of that instruction with the destination indices and write enables of the two older instructions, which are held in the execute/memory and memory/writeback pipeline registers. From those comparisons it derives one 2-bit select per operand. The select then steers a three-way mux that passes the value read at decode, the ALU result one stage ahead, or the writeback value two stages ahead.

The unit is purely combinational. The pipeline around it supplies both source indices through the decode/execute register. The register file writes in the first half of the cycle and reads in the second, so the unit has no bypass path into decode. Register zero can be named as a destination, but its value is never forwarded. When both older instructions write the source register, the younger result, from the execute/memory stage, is used.

Top module: `fwd_unit`

## Requirements
- R1: Each select takes one of three codes: 2'b00 passes the decode-read value, 2'b01 passes the writeback value, and 2'b10 passes the execute/memory ALU result. The code 2'b11 never appears.
- R2: An operand selects 2'b10 and takes `exm_alu` when `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals that operand's source index.
- R3: An operand selects 2'b01 and takes the writeback value when `mwb_wen` is 1, `mwb_dst` is nonzero, `mwb_dst` equals that operand's source index, and the R2 condition for that operand is false.
- R4: When the R2 and R3 conditions both hold for an operand, the select is 2'b10, so the younger result wins.
- R5: A destination index of 0 never causes forwarding, whatever the write enables are.
- R6: A stage whose write enable is 0 never forwards, even when its destination index matches.
- R7: The writeback value is `mwb_load_data` when `mwb_is_load` is 1 and `mwb_alu` otherwise.
- R8: The two operand selects are computed independently. When both source indices name the same register, both operands forward.
- R9: When no stage matches an operand, its select is 2'b00 and the operand equals its decode-read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register index of the execute-stage instruction |
| src_b_idx | input | 5 | Second source register index of the execute-stage instruction |
| rd_val_a | input | 32 | First operand as read from the register file at decode |
| rd_val_b | input | 32 | Second operand as read from the register file at decode |
| exm_wen | input | 1 | Execute/memory instruction writes a register |
| exm_dst | input | 5 | Execute/memory destination index |
| exm_alu | input | 32 | Execute/memory ALU result |
| mwb_wen | input | 1 | Memory/writeback instruction writes a register |
| mwb_dst | input | 5 | Memory/writeback destination index |
| mwb_is_load | input | 1 | Memory/writeback instruction is a load |
| mwb_load_data | input | 32 | Memory/writeback load data |
| mwb_alu | input | 32 | Memory/writeback ALU result |
| sel_a | output | 2 | Bypass select for the first operand |
| sel_b | output | 2 | Bypass select for the second operand |
| opnd_a | output | 32 | First ALU operand after bypass |
| opnd_b | output | 32 | Second ALU operand after bypass |

## Verification
The assertions are evaluated whenever an input changes. They check that the code 2'b11 never appears, that the younger stage wins whenever both stages match, that a zero source index always takes the decode-read value, and that the operands pass through unchanged when neither stage writes. Only the bench scenarios can show the right stage being chosen for each mix of enables and indices, the load-versus-ALU choice for the writeback value, and the independent forwarding of an operand pair that names the same register. A sweep over every register index confirms that register zero is the single index that never forwards.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_OPND = 2;

  typedef enum logic [1:0] {
    SEL_ID  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int AW = 5
) (
  input  logic          wen,
  input  logic [AW-1:0] dst,
  input  logic [AW-1:0] src,
  output logic          hit
);
  logic dst_live;

  always_comb begin
    dst_live = wen && (dst != '0);
    hit      = dst_live && (dst == src);
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          src_is_zero_chk,
  input  logic [AW-1:0] src,
  input  logic          exm_wen,
  input  logic [AW-1:0] exm_dst,
  input  logic          mwb_wen,
  input  logic [AW-1:0] mwb_dst,
  output fwd_sel_e      sel
);
  logic hit_mem;
  logic hit_wb;

  fwd_match #(.AW(AW)) u_match_mem (
    .wen (exm_wen),
    .dst (exm_dst),
    .src (src),
    .hit (hit_mem)
  );

  fwd_match #(.AW(AW)) u_match_wb (
    .wen (mwb_wen),
    .dst (mwb_dst),
    .src (src),
    .hit (hit_wb)
  );

  // Younger stage takes priority over the older one.
  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_ID;
  end

  always_comb begin
    if (!$isunknown({src, exm_wen, exm_dst, mwb_wen, mwb_dst})) begin
      assert_sel_legal_R1: assert (sel != 2'b11)
        else $error("select code 11 produced");
      assert_young_wins_R4: assert (!(hit_mem && hit_wb) || sel == SEL_MEM)
        else $error("older stage chosen over younger");
      assert_zero_src_R5: assert (!(src_is_zero_chk && src == '0) || sel == SEL_ID)
        else $error("register zero forwarded");
    end
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  fwd_sel_e      sel,
  input  logic [DW-1:0] id_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] out_val
);
  always_comb begin
    unique case (sel)
      SEL_MEM: out_val = mem_val;
      SEL_WB:  out_val = wb_val;
      default: out_val = id_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] src_a_idx,
  input  logic [AW-1:0] src_b_idx,
  input  logic [DW-1:0] rd_val_a,
  input  logic [DW-1:0] rd_val_b,
  input  logic          exm_wen,
  input  logic [AW-1:0] exm_dst,
  input  logic [DW-1:0] exm_alu,
  input  logic          mwb_wen,
  input  logic [AW-1:0] mwb_dst,
  input  logic          mwb_is_load,
  input  logic [DW-1:0] mwb_load_data,
  input  logic [DW-1:0] mwb_alu,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  logic [AW-1:0] src_idx [NUM_OPND];
  logic [DW-1:0] id_val  [NUM_OPND];
  logic [DW-1:0] out_val [NUM_OPND];
  fwd_sel_e      sel     [NUM_OPND];
  logic [DW-1:0] wb_val;

  // Writeback mux result, the value that will reach the register file.
  always_comb begin
    wb_val = mwb_is_load ? mwb_load_data : mwb_alu;
  end

  always_comb begin
    src_idx[0] = src_a_idx;
    src_idx[1] = src_b_idx;
    id_val[0]  = rd_val_a;
    id_val[1]  = rd_val_b;
  end

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    fwd_select #(.AW(AW)) u_sel (
      .src_is_zero_chk (1'b1),
      .src             (src_idx[k]),
      .exm_wen         (exm_wen),
      .exm_dst         (exm_dst),
      .mwb_wen         (mwb_wen),
      .mwb_dst         (mwb_dst),
      .sel             (sel[k])
    );

    fwd_mux #(.DW(DW)) u_mux (
      .sel     (sel[k]),
      .id_val  (id_val[k]),
      .mem_val (exm_alu),
      .wb_val  (wb_val),
      .out_val (out_val[k])
    );
  end

  always_comb begin
    sel_a  = sel[0];
    sel_b  = sel[1];
    opnd_a = out_val[0];
    opnd_b = out_val[1];
  end

  always_comb begin
    if (!$isunknown({src_a_idx, src_b_idx, exm_wen, mwb_wen, rd_val_a, rd_val_b})) begin
      assert_idle_pass_R6: assert (exm_wen || mwb_wen || (opnd_a == rd_val_a && opnd_b == rd_val_b))
        else $error("operand altered with no writing stage");
      assert_zero_pass_R5: assert (src_a_idx != '0 || opnd_a == rd_val_a)
        else $error("register zero operand altered");
    end
  end
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam logic [31:0] VA = 32'hA0A0_0001;
  localparam logic [31:0] VB = 32'hB0B0_0002;
  localparam logic [31:0] VE = 32'hE0E0_0003;
  localparam logic [31:0] VW = 32'h5050_0004;
  localparam logic [31:0] VL = 32'h7070_0005;

  typedef struct packed {
    logic [4:0] sa;
    logic [4:0] sb;
    logic       ew;
    logic [4:0] ed;
    logic       mw;
    logic [4:0] md;
    logic       ml;
    logic [1:0] xa;
    logic [1:0] xb;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{5'd3,  5'd4,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 4'd9}, // R9 no match
    '{5'd2,  5'd5,  1'b1, 5'd2,  1'b0, 5'd0,  1'b0, 2'b10, 2'b00, 4'd2}, // R2 first operand
    '{5'd6,  5'd2,  1'b1, 5'd2,  1'b0, 5'd0,  1'b0, 2'b00, 2'b10, 4'd2}, // R2 second operand
    '{5'd2,  5'd5,  1'b0, 5'd0,  1'b1, 5'd2,  1'b0, 2'b01, 2'b00, 4'd3}, // R3 alu writeback
    '{5'd6,  5'd2,  1'b0, 5'd0,  1'b1, 5'd2,  1'b1, 2'b00, 2'b01, 4'd7}, // R7 load writeback
    '{5'd1,  5'd1,  1'b1, 5'd1,  1'b1, 5'd1,  1'b0, 2'b10, 2'b10, 4'd4}, // R4 both match
    '{5'd3,  5'd7,  1'b1, 5'd3,  1'b1, 5'd7,  1'b0, 2'b10, 2'b01, 4'd8}, // R8 mixed sources
    '{5'd2,  5'd2,  1'b0, 5'd0,  1'b1, 5'd2,  1'b1, 2'b01, 2'b01, 4'd8}, // R8 same source twice
    '{5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  1'b0, 2'b00, 2'b00, 4'd5}, // R5 zero destination
    '{5'd4,  5'd9,  1'b0, 5'd4,  1'b1, 5'd4,  1'b0, 2'b01, 2'b00, 4'd6}, // R6 young stage idle
    '{5'd4,  5'd4,  1'b0, 5'd4,  1'b0, 5'd4,  1'b0, 2'b00, 2'b00, 4'd6}, // R6 both idle
    '{5'd8,  5'd9,  1'b1, 5'd9,  1'b1, 5'd8,  1'b0, 2'b01, 2'b10, 4'd3}, // R3 split match
    '{5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 5'd31, 1'b1, 2'b10, 2'b00, 4'd4}, // R4 top index
    '{5'd5,  5'd0,  1'b1, 5'd0,  1'b1, 5'd5,  1'b1, 2'b01, 2'b00, 4'd5}  // R5 zero young dst
  };

  logic clk;
  logic [4:0]  src_a_idx, src_b_idx, exm_dst, mwb_dst;
  logic [31:0] rd_val_a, rd_val_b, exm_alu, mwb_load_data, mwb_alu;
  logic        exm_wen, mwb_wen, mwb_is_load;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;
  int checks;
  int failures;
  bit done;

  fwd_unit u_fwd_unit (
    .src_a_idx     (src_a_idx),
    .src_b_idx     (src_b_idx),
    .rd_val_a      (rd_val_a),
    .rd_val_b      (rd_val_b),
    .exm_wen       (exm_wen),
    .exm_dst       (exm_dst),
    .exm_alu       (exm_alu),
    .mwb_wen       (mwb_wen),
    .mwb_dst       (mwb_dst),
    .mwb_is_load   (mwb_is_load),
    .mwb_load_data (mwb_load_data),
    .mwb_alu       (mwb_alu),
    .sel_a         (sel_a),
    .sel_b         (sel_b),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] idv,
                                       input logic ld);
    if (s == 2'b10)      return VE;
    else if (s == 2'b01) return ld ? VL : VW;
    else                 return idv;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] sa, input logic [4:0] sb, input logic ew,
                       input logic [4:0] ed, input logic mw, input logic [4:0] md,
                       input logic ml);
    @(negedge clk);
    src_a_idx = sa; src_b_idx = sb;
    exm_wen = ew; exm_dst = ed; mwb_wen = mw; mwb_dst = md; mwb_is_load = ml;
    #2;
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rd_val_a = VA; rd_val_b = VB; exm_alu = VE; mwb_alu = VW; mwb_load_data = VL;
    src_a_idx = '0; src_b_idx = '0; exm_wen = 1'b0; exm_dst = '0;
    mwb_wen = 1'b0; mwb_dst = '0; mwb_is_load = 1'b0;

    // Idle start: everything passes the decode values (R9).
    drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
    check("R9 idle sel_a", {30'd0, sel_a}, 32'd0);
    check("R9 idle opnd_b", opnd_b, VB);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].sa, VEC[i].sb, VEC[i].ew, VEC[i].ed, VEC[i].mw, VEC[i].md, VEC[i].ml);
      check($sformatf("R%0d/R1 vec%0d sel_a", VEC[i].req, i), {30'd0, sel_a}, {30'd0, VEC[i].xa});
      check($sformatf("R%0d/R1 vec%0d sel_b", VEC[i].req, i), {30'd0, sel_b}, {30'd0, VEC[i].xb});
      check($sformatf("R%0d vec%0d opnd_a", VEC[i].req, i), opnd_a, pick(VEC[i].xa, VA, VEC[i].ml));
      check($sformatf("R%0d vec%0d opnd_b", VEC[i].req, i), opnd_b, pick(VEC[i].xb, VB, VEC[i].ml));
    end

    // R5 sweep: both stages write index s; only index 0 stays unforwarded.
    for (int s = 0; s < 32; s++) begin
      drive(5'(s), 5'(s), 1'b1, 5'(s), 1'b1, 5'(s), 1'b0);
      check($sformatf("R5 sweep idx%0d sel_a", s), {30'd0, sel_a},
            (s == 0) ? 32'd0 : 32'd2);
    end

    // R6 sweep: matching destinations with writes disabled never forward.
    for (int s = 1; s < 32; s += 5) begin
      drive(5'(s), 5'(s), 1'b0, 5'(s), 1'b0, 5'(s), 1'b1);
      check($sformatf("R6 sweep idx%0d opnd_a", s), opnd_a, VA);
    end

    // R7: same match, load flag toggled, writeback value follows it.
    drive(5'd12, 5'd3, 1'b0, 5'd0, 1'b1, 5'd12, 1'b0);
    check("R7 alu path", opnd_a, VW);
    drive(5'd12, 5'd3, 1'b0, 5'd0, 1'b1, 5'd12, 1'b1);
    check("R7 load path", opnd_a, VL);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule